// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer for 9-bit words. Its depth is a parameter and must be a power of two of at least 256. A write needs both of its enables, and so does a read. The block reports four things about how full it is:

- an empty flag;
- a full flag;
- a low-water flag, raised when the buffer holds no more than a programmable number of words;
- a high-water flag, raised when no more than a programmable number of free slots remain.

Both thresholds start at seven after reset. They can be changed through the data input. While the load strobe is high, each cycle with both write enables asserted stores one part of a threshold instead of a data word. A four-state sequencer selects the part:

- `LD_AE_LO`: low part of the low-water threshold;
- `LD_AE_HI`: high part of the low-water threshold;
- `LD_AF_LO`: low part of the high-water threshold;
- `LD_AF_HI`: high part of the high-water threshold.

A load step moves the sequencer along `LD_AE_LO -> LD_AE_HI -> LD_AF_LO -> LD_AF_HI -> LD_AE_LO`. A cycle with the load strobe high and no write leaves it where it is. Any cycle with the load strobe low returns it to `LD_AE_LO`. The read data is registered. An output-enable input forces the data output to zero when low.

Top module: `sfifo_prog`

## Requirements
- R1: Words leave the buffer in the order they were written, with all 9 bits intact.
- R2: A word is stored on a rising edge only when `wr_en_n` is 0, `wr_en` is 1 and `load` is 0. Any other combination stores nothing.
- R3: A read is accepted on a rising edge only when `rd_en_n` is 0 and `rd_en` is 1. After that edge the read register holds the oldest word. With no accepted read it keeps its value.
- R4: `empty` is 1 exactly when 0 words are held. `full` is 1 exactly when DEPTH words are held. Both flags change on the edge that changes the fill level.
- R5: A write attempt while `full` is 1 changes neither the contents nor the flags. A read attempt while `empty` is 1 leaves the read register and the flags unchanged.
- R6: After reset, `almost_empty` is 1 when at most 7 words are held, and `almost_full` is 1 when at most 7 slots are free.
- R7: A cycle with `load` high and both write enables asserted is a load step that stores no data. Bits [7:0] of the threshold are taken from `din[7:0]`; bit 8 and above are taken from the lowest `din` bits. The steps fill, in order: low-water bits [7:0], low-water bits [8 and up], high-water bits [7:0], high-water bits [8 and up]. The order then wraps to the first part.
- R8: A cycle with `load` low restarts the load order at low-water bits [7:0]. A load-high cycle with no write holds the position.
- R9: With thresholds AE and AF, `almost_empty` is 1 when the level is at most AE, and `almost_full` is 1 when DEPTH minus the level is at most AF.
- R10: `dout` is zero while `oe` is 0 and equals the read register while `oe` is 1. `oe` has no effect on reads.
- R11: While `rst_n` is low, the block is empty, `full` is 0, `almost_empty` is 1, `almost_full` is 0, `dout` is 0 and both thresholds are 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 9 | Write data, or threshold part during a load step |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en | input | 1 | Write enable, active high |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high |
| load | input | 1 | Steers write cycles into the threshold sequencer |
| oe | input | 1 | Output qualify; 0 forces `dout` to zero |
| dout | output | 9 | Registered read data |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| almost_empty | output | 1 | Level at or below the low-water threshold |
| almost_full | output | 1 | Free slots at or below the high-water threshold |

## Verification
Two pairs of functions can fall in the same cycle:

- A read and a write. This pairing is forced at level zero, where only the write may take effect, and at DEPTH, where only the read may take effect.
- A threshold load step and a read. Here the read must proceed while the write port is diverted into the sequencer.

Random traffic with mixed enables and occasional load strobes provokes both pairings many times. Every cycle is judged against a bench queue model that applies the acceptance rules separately to each port. Directed passes add the exact full and empty boundaries, which random traffic rarely reaches.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int PART_W = 8;

    typedef enum logic [1:0] {
        LD_AE_LO = 2'd0,
        LD_AE_HI = 2'd1,
        LD_AF_LO = 2'd2,
        LD_AF_HI = 2'd3
    } ld_state_t;
endpackage

// File: rtl/sfifo_ofs_loader.sv
module sfifo_ofs_loader
    import sfifo_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int OFS_W   = 9,
    parameter int DEF_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs
);
    localparam int HI_W = OFS_W - PART_W;

    ld_state_t state, state_nx;
    logic      step;

    assign step = load & wr_req;

    // next-state selection
    always_comb begin
        state_nx = state;
        if (!load) begin
            state_nx = LD_AE_LO;
        end else if (step) begin
            unique case (state)
                LD_AE_LO: state_nx = LD_AE_HI;
                LD_AE_HI: state_nx = LD_AF_LO;
                LD_AF_LO: state_nx = LD_AF_HI;
                LD_AF_HI: state_nx = LD_AE_LO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_AE_LO;
        else        state <= state_nx;
    end

    // outputs: threshold registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OFS_W'(DEF_OFS);
            af_ofs <= OFS_W'(DEF_OFS);
        end else if (step) begin
            unique case (state)
                LD_AE_LO: ae_ofs[PART_W-1:0]     <= din[PART_W-1:0];
                LD_AE_HI: ae_ofs[OFS_W-1:PART_W] <= din[HI_W-1:0];
                LD_AF_LO: af_ofs[PART_W-1:0]     <= din[PART_W-1:0];
                LD_AF_HI: af_ofs[OFS_W-1:PART_W] <= din[HI_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            rdata <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) begin
                rptr  <= rptr + 1'b1;
                rdata <= mem[rptr];
            end
        end
    end
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             rd_ok,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] vacant;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign vacant       = CNT_W'(DEPTH) - level;
    assign empty        = (level == '0);
    assign full         = (level == CNT_W'(DEPTH));
    assign almost_empty = ({1'b0, level} <= {1'b0, ae_ofs});
    assign almost_full  = ({1'b0, vacant} <= {1'b0, af_ofs});
endmodule

// File: rtl/sfifo_prog.sv
module sfifo_prog #(
    parameter int DATA_W  = 9,
    parameter int DEPTH   = 256,
    parameter int DEF_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en_n,
    input  logic              wr_en,
    input  logic              rd_en_n,
    input  logic              rd_en,
    input  logic              load,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int OFS_W = $clog2(DEPTH) + 1;

    logic              wr_req, rd_req, wr_ok, rd_ok;
    logic [OFS_W-1:0]  ae_ofs, af_ofs;
    logic [DATA_W-1:0] rdata;

    assign wr_req = ~wr_en_n & wr_en;
    assign rd_req = ~rd_en_n & rd_en;
    assign wr_ok  = wr_req & ~load & ~full;
    assign rd_ok  = rd_req & ~empty;

    sfifo_ofs_loader #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_loader (
        .clk(clk), .rst_n(rst_n), .load(load), .wr_req(wr_req), .din(din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok), .din(din),
        .rdata(rdata)
    );

    sfifo_level #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_level (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    assign dout = oe ? rdata : '0;
endmodule

// File: rtl/sfifo_prog_chk.sv
module sfifo_prog_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic              rd_req,
    input logic              load,
    input logic [DATA_W-1:0] rdata,
    input logic              empty,
    input logic              full,
    input logic              almost_empty,
    input logic              almost_full
);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_req && !rd_req |=> full);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_req && !(wr_req && !load) |=> empty && $stable(rdata));

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    assert_empty_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);

    assert_full_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

    assert_load_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load && wr_req && !rd_req |=> $stable(empty) && $stable(full));

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !load && !full && !rd_req |=> !empty);

    assert_read_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !empty && !(wr_req && !load) |=> !full);
endmodule

bind sfifo_prog sfifo_prog_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .load(load),
    .rdata(rdata), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
);

// File: tb/tb_sfifo_prog.sv
`timescale 1ns/1ps
module tb_sfifo_prog;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 256;
    localparam int OFS_W  = $clog2(DEPTH) + 1;
    localparam int HI_W   = OFS_W - 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              wr_en_n = 1'b1, wr_en = 1'b0, rd_en_n = 1'b1, rd_en = 1'b0;
    logic              load = 1'b0, oe = 1'b1;
    logic [DATA_W-1:0] dout;
    logic              empty, full, almost_empty, almost_full;

    int n_chk = 0, n_bad = 0;

    logic [DATA_W-1:0] q_m[$];
    logic [DATA_W-1:0] rd_m = '0;
    logic [OFS_W-1:0]  ae_m = OFS_W'(7), af_m = OFS_W'(7);
    int                ls_m = 0;

    always #4 clk = ~clk;

    sfifo_prog #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en_n(wr_en_n), .wr_en(wr_en),
        .rd_en_n(rd_en_n), .rd_en(rd_en), .load(load), .oe(oe), .dout(dout),
        .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    function automatic logic exp_ae();
        return q_m.size() <= int'(ae_m);
    endfunction

    function automatic logic exp_af();
        return (DEPTH - q_m.size()) <= int'(af_m);
    endfunction

    task automatic chk(input string what, input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk("dout", tag, int'(dout), oe ? int'(rd_m) : 0);
        chk("empty", tag, int'(empty), int'(q_m.size() == 0));
        chk("full", tag, int'(full), int'(q_m.size() == DEPTH));
        chk("almost_empty", tag, int'(almost_empty), int'(exp_ae()));
        chk("almost_full", tag, int'(almost_full), int'(exp_af()));
    endtask

    // called just after a falling edge
    task automatic step(input logic w1n, input logic w2, input logic r1n, input logic r2,
                        input logic l, input logic o, input logic [DATA_W-1:0] d,
                        input string tag);
        logic wr, rd, rd_ok, wr_ok;
        wr_en_n = w1n; wr_en = w2; rd_en_n = r1n; rd_en = r2; load = l; oe = o; din = d;
        wr = !w1n && w2;
        rd = !r1n && r2;
        rd_ok = rd && q_m.size() > 0;
        wr_ok = wr && !l && q_m.size() < DEPTH;
        if (l && wr) begin
            case (ls_m)
                0: ae_m[7:0] = d[7:0];
                1: ae_m[OFS_W-1:8] = d[HI_W-1:0];
                2: af_m[7:0] = d[7:0];
                default: af_m[OFS_W-1:8] = d[HI_W-1:0];
            endcase
            ls_m = (ls_m + 1) % 4;
        end else if (!l) begin
            ls_m = 0;
        end
        if (rd_ok) rd_m = q_m.pop_front();
        if (wr_ok) q_m.push_back(d);
        @(posedge clk);
        #2;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic wr1(input logic [DATA_W-1:0] d, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, d, tag);
    endtask

    task automatic rd1(input string tag);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '0, tag);
    endtask

    task automatic ld1(input logic [DATA_W-1:0] d, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, d, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: actual hung expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_F1F0));
        // R11: reset values
        repeat (3) @(negedge clk);
        chk("dout", "R11", int'(dout), 0);
        chk("empty", "R11", int'(empty), 1);
        chk("full", "R11", int'(full), 0);
        chk("almost_empty", "R11", int'(almost_empty), 1);
        chk("almost_full", "R11", int'(almost_full), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: partial write enables store nothing
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1AA, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h155, "R2");
        // R5: read at empty ignored
        rd1("R5");
        // R1: ordering, R6: low-water flag at default threshold
        for (int i = 0; i < 9; i++) wr1(9'(i * 37 + 5), "R6");
        // R3: partial read enables do not read
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R3");
        for (int i = 0; i < 9; i++) rd1("R1");
        rd1("R5");
        // R4 fill, R6 high-water, R5 overflow with and without simultaneous read
        for (int i = 0; i < DEPTH; i++) wr1(9'(i * 7 + 3), "R4");
        wr1(9'h1FF, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h0F0, "R5");
        wr1(9'h1EE, "R5");
        // R10: oe low hides data but reads still advance
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R10");
        for (int i = 0; i < DEPTH; i++) rd1("R1");
        // simultaneous read and write at empty: write only
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h123, "R5");
        rd1("R3");

        // R7: load ae=20, hold, af=300, wrap to ae low
        ld1(9'd20, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 9'h1FF, "R8");
        ld1(9'd0, "R7");
        ld1(9'd44, "R7");
        ld1(9'd1, "R7");
        ld1(9'd25, "R7");
        // R8: drop load, next step restarts at ae low
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R8");
        ld1(9'd30, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R8");
        // R9: sweep level across both loaded thresholds
        for (int i = 0; i < DEPTH; i++) wr1(9'(i ^ 9'h0A5), "R9");
        // load step with a read in the same cycle
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9'd9, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R8");
        for (int i = 0; i < DEPTH; i++) rd1("R9");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            int ph, pw;
            logic w, r, l;
            ph = (i / 500) % 3;
            pw = (ph == 0) ? 70 : (ph == 1) ? 35 : 50;
            w = ($urandom % 100) < pw;
            r = ($urandom % 100) < (100 - pw);
            l = ($urandom % 100) < 3;
            step(w ? 1'b0 : 1'($urandom % 2), w ? 1'b1 : 1'b0,
                 r ? 1'b0 : 1'b1, r ? 1'b1 : 1'($urandom % 2),
                 l, ($urandom % 10) != 0, 9'($urandom), "R1");
        end
        finish_run();
    end
endmodule